// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a small word-addressed store in which every data word has a one-bit presence tag that says whether the word is full or empty. Producers and consumers use it for word-level handoff. A producer deposits a value with a "put" request, which succeeds only into an empty word and marks it full. A consumer removes the value with a "take" request, which succeeds only on a full word and marks it empty. When the tag does not allow the access, the request is answered with a retry indication and nothing in the store changes. The requester then polls again later.

Plain loads and stores are also provided. They move data without looking at or changing the tag, so software can initialise or inspect words outside the handoff protocol. There is one request port with a valid/ready handshake. Each accepted request gets exactly one response, one cycle later. Tag update and data access happen on the same clock edge, so a following request always sees both changes or neither.

Top module: `fe_word_mem`

## Requirements
- R1: While reset is asserted, and after every reset, all tags are empty. A take (opcode 2'b10) to any word after reset answers with retry (rsp_retry = 1).
- R2: A put (opcode 2'b11) to an empty word answers rsp_retry = 0 and rsp_rdata = 0. It stores req_wdata and marks the word full, so a later take returns that value.
- R3: A put to a full word answers rsp_retry = 1. The stored word keeps its unconsumed value and stays full.
- R4: A take to a full word answers rsp_retry = 0 with the stored value on rsp_rdata, and leaves the word empty. A second take to it then retries.
- R5: A take to an empty word answers rsp_retry = 1 and rsp_rdata = 0, and leaves the word and its tag as they were.
- R6: A plain store (opcode 2'b01) writes req_wdata and answers rsp_retry = 0, rsp_rdata = 0. It never changes the tag of any word.
- R7: A plain load (opcode 2'b00) answers rsp_retry = 0 with the stored value, and never changes any tag.
- R8: rsp_valid is high in exactly the cycle after a request is accepted (req_valid and req_ready both high at a rising edge), and low otherwise.
- R9: req_ready is low while reset is asserted and goes high within a few cycles of reset release. Back-to-back accepted requests each observe the complete effect of the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 00 plain load, 01 plain store, 10 take, 11 put |
| req_addr | input | ADDR_W | Word index |
| req_wdata | input | DATA_W | Data for plain store and put |
| rsp_valid | output | 1 | Response present |
| rsp_retry | output | 1 | 1 when a take or put was refused by the tag |
| rsp_rdata | output | DATA_W | Word read by a plain load or a granted take; zero otherwise |

## Verification
The bench sweeps every word through several sequences: take on an empty word, put on an empty word, a repeated put on a full word, take, and a repeated take. A design that let a second put through would overwrite unconsumed data and show the new value on the next take. A design that left the tag set after a take would grant the repeated take. Plain stores are applied to full and to empty words, and a following take must still succeed or retry exactly as before. This catches a plain path that wrongly touches the tag. A reset in the middle of the run, with many words full, must leave every word empty, and the idle cycles between requests must show no stray response.

// File: rtl/fe_word_pkg.sv
package fe_word_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_TAKE  = 2'b10,
    OP_PUT   = 2'b11
  } fe_op_e;

endpackage

// File: rtl/fe_tag_bank.sv
module fe_tag_bank #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] idx,
  output logic             tag_o,
  output logic [DEPTH-1:0] tags_o
);

  logic [DEPTH-1:0] tags_q;
  logic [DEPTH-1:0] tags_d;

  // one presence cell per word
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic hit;
    assign hit = (idx == IDX_W'(g));
    always_comb begin
      tags_d[g] = tags_q[g];
      if (hit && set_en) tags_d[g] = 1'b1;
      else if (hit && clr_en) tags_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tags_q <= '0;
    else        tags_q <= tags_d;
  end

  assign tag_o  = tags_q[idx];
  assign tags_o = tags_q;

  AST_SET_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en)); // R2
  AST_PUT_MARKS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> tags_q[$past(idx)]); // R2
  AST_TAKE_MARKS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !tags_q[$past(idx)]); // R4

endmodule

// File: rtl/fe_data_bank.sv
module fe_data_bank #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(addr)] == $past(wdata))); // R6

endmodule

// File: rtl/fe_access_ctrl.sv
module fe_access_ctrl
  import fe_word_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              fire,
  input  fe_op_e            op,
  input  logic              tag_cur,
  input  logic [DATA_W-1:0] rd_word,
  output logic              we,
  output logic              tag_set,
  output logic              tag_clr,
  output logic              retry_d,
  output logic [DATA_W-1:0] rdata_d
);

  always_comb begin
    we      = 1'b0;
    tag_set = 1'b0;
    tag_clr = 1'b0;
    retry_d = 1'b0;
    rdata_d = '0;
    if (fire) begin
      unique case (op)
        OP_LOAD:  rdata_d = rd_word;
        OP_STORE: we = 1'b1;
        OP_TAKE: begin
          if (tag_cur) begin
            rdata_d = rd_word;
            tag_clr = 1'b1;
          end else begin
            retry_d = 1'b1;
          end
        end
        OP_PUT: begin
          if (!tag_cur) begin
            we      = 1'b1;
            tag_set = 1'b1;
          end else begin
            retry_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fe_word_mem.sv
module fe_word_mem
  import fe_word_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_retry,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic              ready_q;
  logic              fire;
  fe_op_e            op;
  logic              tag_cur;
  logic [DEPTH-1:0]  tags_all;
  logic [DATA_W-1:0] rd_word;
  logic              we;
  logic              tag_set;
  logic              tag_clr;
  logic              retry_d;
  logic [DATA_W-1:0] rdata_d;

  assign op        = fe_op_e'(req_op);
  assign req_ready = ready_q;
  assign fire      = req_valid && ready_q;

  fe_tag_bank #(.DEPTH(DEPTH), .IDX_W(ADDR_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .set_en (tag_set),
    .clr_en (tag_clr),
    .idx    (req_addr),
    .tag_o  (tag_cur),
    .tags_o (tags_all)
  );

  fe_data_bank #(.DEPTH(DEPTH), .IDX_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .rst_n (rst_n_i),
    .we    (we),
    .addr  (req_addr),
    .wdata (req_wdata),
    .rdata (rd_word)
  );

  fe_access_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .fire    (fire),
    .op      (op),
    .tag_cur (tag_cur),
    .rd_word (rd_word),
    .we      (we),
    .tag_set (tag_set),
    .tag_clr (tag_clr),
    .retry_d (retry_d),
    .rdata_d (rdata_d)
  );

  // response registers
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_retry_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  assign rsp_valid_d = fire;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_retry_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= rsp_valid_d;
      if (fire) begin
        rsp_retry_q <= retry_d;
        rsp_rdata_q <= rdata_d;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_retry = rsp_retry_q;
  assign rsp_rdata = rsp_rdata_q;

  AST_RSP_FOLLOWS_FIRE: assert property (@(posedge clk) disable iff (!rst_n_i)
    fire |=> rsp_valid); // R8
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n_i)
    !fire |=> !rsp_valid); // R8
  AST_PUT_FULL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fire && op == OP_PUT && tag_cur) |=> ($stable(tags_all) && rsp_retry)); // R3
  AST_TAKE_EMPTY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fire && op == OP_TAKE && !tag_cur) |=> ($stable(tags_all) && rsp_retry)); // R5
  AST_PLAIN_KEEPS_TAGS: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fire && !req_op[1]) |=> $stable(tags_all)); // R6
  AST_GRANTED_TAKE_WAS_FULL: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rsp_valid && !rsp_retry && $past(req_op) == 2'b10) |-> $past(tag_cur)); // R4

endmodule

// File: tb/fe_word_mem_test.sv
module fe_word_mem_test;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic          rsp_retry;
  logic [DW-1:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_data [N];
  bit            m_tag  [N];

  always #4 clk = ~clk; // 125 MHz

  fe_word_mem #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // issue one request, compute the expected answer from the model
  task automatic run(input logic [1:0] op, input int a,
                     input logic [DW-1:0] wd, input string req);
    logic          e_retry;
    logic [DW-1:0] e_data;
    e_retry = 1'b0;
    e_data  = '0;
    case (op)
      2'b00: e_data = m_data[a];
      2'b01: m_data[a] = wd;
      2'b10: if (m_tag[a]) begin e_data = m_data[a]; m_tag[a] = 1'b0; end
             else e_retry = 1'b1;
      default: if (!m_tag[a]) begin m_data[a] = wd; m_tag[a] = 1'b1; end
               else e_retry = 1'b1;
    endcase
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = AW'(a);
    req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    chk("R8", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_retry", 32'(rsp_retry), 32'(e_retry));
    chk(req, "rsp_rdata", 32'(rsp_rdata), 32'(e_data));
    req_valid = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 8 && !req_ready; i++) @(negedge clk);
    chk("R9", "req_ready after reset", 32'(req_ready), 32'd1);
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < N; i++) begin m_tag[i] = 1'b0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R9", "req_ready in reset", 32'(req_ready), 32'd0);
    chk("R8", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    wait_ready();

    // R1 / R5: everything empty after reset
    for (int a = 0; a < N; a++) run(2'b10, a, '0, "R1");
    // R6 / R7: plain store then plain load, tag untouched
    for (int a = 0; a < N; a++) run(2'b01, a, DW'(a * 7 + 3), "R6");
    for (int a = 0; a < N; a++) run(2'b00, a, '0, "R7");
    for (int a = 0; a < N; a++) run(2'b10, a, '0, "R5");
    // R2 / R3 / R4 sequence, back to back per word (R9)
    for (int a = 0; a < N; a++) begin
      run(2'b11, a, DW'(a * 13 + 5), "R2");
      run(2'b11, a, DW'(a * 3 + 200), "R3");
      run(2'b00, a, '0, "R3");
      run(2'b00, a, '0, "R7");
      run(2'b10, a, '0, "R4");
      run(2'b10, a, '0, "R4");
    end
    // R6 on a full word: new data, still full
    for (int a = 0; a < N; a += 3) begin
      run(2'b11, a, DW'(a + 90), "R2");
      run(2'b01, a, DW'(a * 5 + 1), "R6");
      run(2'b10, a, '0, "R6");
      run(2'b10, a, '0, "R5");
    end
    // R8: idle cycles give no response
    @(negedge clk);
    chk("R8", "idle rsp_valid", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R8", "idle rsp_valid", 32'(rsp_valid), 32'd0);
    // fill odd words, then reset mid-run
    for (int a = 1; a < N; a += 2) run(2'b11, a, DW'(a ^ 8'h5a), "R2");
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) m_tag[i] = 1'b0;
    @(negedge clk);
    chk("R9", "req_ready in reset", 32'(req_ready), 32'd0);
    rst_n = 1'b1;
    wait_ready();
    for (int a = 0; a < N; a++) run(2'b10, a, '0, "R1");
    for (int a = 0; a < N; a++) run(2'b00, a, '0, "R7");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule